// File: doc/BRIEF.md
# Serial Receive Line Monitor with Statistics

This block watches one asynchronous serial receive line and keeps running statistics about the traffic it sees. It is meant to sit in a test fixture opposite a device under test. The device transmits words, and the test controller reads back how many words arrived, their arithmetic sum, the last word, and three separate error tallies. All of these values are readable while reception is in progress.

The frame format is chosen at run time. It supports 7, 8 or 9 data bits, parity that is absent, odd or even, and one or two stop bits. The bit time is a divisor given in clock cycles. A run-enable input gates the start of new frames. A separate clear input zeroes the statistics, so several runs can be added together and then cleared when the controller chooses. An optional flow-control output tells the far end when the monitor is willing to accept data.

Each frame has a start bit (low), the data bits with the least significant bit first, an optional parity bit, and then the stop bits (high). A falling edge on the line arms the receiver. The line is sampled half a bit later to confirm the start. Every later bit is sampled at its own middle.

Top module: `uart_rx_stats`

## Requirements
- R1: While `rst` is high and after it is released, all counters, `checksum` and `last_word` are zero and `rts_n` is high.
- R2: `cfg_len` selects the data length: code 0 gives 7 bits, code 1 gives 8 bits, code 2 gives 9 bits, and code 3 is treated as 8 bits. Data bits are received least significant bit first. `last_word` holds the most recent word right-aligned, with the unused upper bits at zero.
- R3: `cfg_par` selects the parity: code 0 is none, code 1 is odd, code 2 is even, and code 3 is treated as none. When the parity bit does not match the data bits, `parity_errs` increments by one. With no parity, no parity bit is expected and `parity_errs` never changes.
- R4: When `cfg_two_stop` is 0, one stop bit is expected. When it is 1, two stop bits are expected. If any stop bit is sampled low, `stop_errs` increments by exactly one for that frame.
- R5: Every completed frame increments `word_count` by one and adds its data word to the 32-bit `checksum`, which wraps on overflow. This applies even when the frame has a parity or stop error.
- R6: A falling edge whose line is no longer low at mid-bit increments `frame_errs` by one. It does not count a word and does not change `checksum`.
- R7: While `run_en` is low, no new frame is started and the statistics hold their values. When `run_en` goes high again, counting continues from the held values.
- R8: A pulse on `stat_clear` zeroes `word_count`, `checksum`, `last_word` and all three error counters on the next clock edge.
- R9: With `HAS_RTS` = 1, `rts_n` goes low one cycle after `run_en` goes high and goes high one cycle after `run_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Allows new frames to start |
| stat_clear | input | 1 | Zeroes the statistics |
| cfg_div | input | DIV_W | Clock cycles per bit, at least 4 |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| rxd | input | 1 | Serial line, idle high |
| rts_n | output | 1 | Low when ready to receive |
| word_count | output | CNT_W | Completed frames |
| checksum | output | 32 | Wrapping sum of received words |
| last_word | output | 9 | Most recent data word |
| parity_errs | output | ERR_W | Parity mismatches |
| stop_errs | output | ERR_W | Frames with a low stop bit |
| frame_errs | output | ERR_W | Start bits not confirmed |

## Verification
The bench builds the block with its default parameters: `DIV_W`=16, `CNT_W`=32, `ERR_W`=16, two synchronizer stages, and the flow-control output present. It drives a divisor of 16 cycles per bit, so the mid-bit sampling point falls 8 cycles into each bit. A 3-cycle low glitch therefore lands well before that point and produces a framing error. With the flow-control output enabled, the one-cycle `rts_n` response is checked directly, and frames of every length, parity and stop combination fit comfortably in a short run.

// File: rtl/uart_rx_stats_pkg.sv
package uart_rx_stats_pkg;
  localparam int MAX_BITS = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0, PAR_ODD = 2'd1, PAR_EVEN = 2'd2, PAR_NONE_ALT = 2'd3
  } par_mode_t;

  typedef struct packed {
    logic                word_done;
    logic                frame_err;
    logic                par_err;
    logic                stop_err;
    logic [MAX_BITS-1:0] word;
  } rx_event_t;

  function automatic logic [3:0] len_from_code(input logic [1:0] code);
    case (code)
      2'd0:    len_from_code = 4'd7;
      2'd2:    len_from_code = 4'd9;
      default: len_from_code = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_stats_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_two_stop,
  input  logic             rx_s,
  output rx_event_t        evt
);
  rx_state_t           state;
  logic [DIV_W-1:0]    cnt;
  logic [3:0]          bidx;
  logic [3:0]          nbits;
  par_mode_t           pmode;
  logic                two_stop;
  logic                rx_q;
  logic                p_acc;
  logic                perr;
  logic                serr;
  logic [MAX_BITS-1:0] sh;

  logic [DIV_W-1:0] half_m1;
  logic [DIV_W-1:0] full_m1;
  logic             bit_end;
  logic [MAX_BITS-1:0] aligned;

  assign half_m1 = (cfg_div >> 1) - 1'b1;
  assign full_m1 = cfg_div - 1'b1;
  assign bit_end = (cnt == full_m1);

  always_comb begin
    case (nbits)
      4'd7:    aligned = {2'b00, sh[MAX_BITS-1:2]};
      4'd8:    aligned = {1'b0, sh[MAX_BITS-1:1]};
      default: aligned = sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      nbits    <= 4'd8;
      pmode    <= PAR_NONE;
      two_stop <= 1'b0;
      rx_q     <= 1'b1;
      p_acc    <= 1'b0;
      perr     <= 1'b0;
      serr     <= 1'b0;
      sh       <= '0;
      evt      <= '0;
    end else begin
      rx_q          <= rx_s;
      evt.word_done <= 1'b0;
      evt.frame_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (run_en && rx_q && !rx_s) begin
            state    <= ST_START;
            nbits    <= len_from_code(cfg_len);
            pmode    <= par_mode_t'(cfg_par);
            two_stop <= cfg_two_stop;
            bidx     <= '0;
            p_acc    <= 1'b0;
            perr     <= 1'b0;
            serr     <= 1'b0;
          end
        end
        ST_START: begin
          if (cnt == half_m1) begin
            cnt <= '0;
            if (!rx_s) state <= ST_DATA;
            else begin
              state         <= ST_IDLE;
              evt.frame_err <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            sh    <= {rx_s, sh[MAX_BITS-1:1]};
            p_acc <= p_acc ^ rx_s;
            if (bidx == nbits - 4'd1) begin
              state <= (pmode == PAR_ODD || pmode == PAR_EVEN) ? ST_PAR : ST_STOP1;
            end else bidx <= bidx + 4'd1;
          end else cnt <= cnt + 1'b1;
        end
        ST_PAR: begin
          if (bit_end) begin
            cnt   <= '0;
            perr  <= (pmode == PAR_ODD) ? ~(p_acc ^ rx_s) : (p_acc ^ rx_s);
            state <= ST_STOP1;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP1, ST_STOP2: begin
          if (bit_end) begin
            cnt <= '0;
            if (state == ST_STOP1 && two_stop) begin
              serr  <= ~rx_s;
              state <= ST_STOP2;
            end else begin
              evt.word_done <= 1'b1;
              evt.word      <= aligned;
              evt.par_err   <= perr;
              evt.stop_err  <= serr | ~rx_s;
              state         <= ST_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_tally.sv
module uart_rx_tally
  import uart_rx_stats_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ERR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  rx_event_t           evt,
  output logic [CNT_W-1:0]    word_count,
  output logic [31:0]         checksum,
  output logic [MAX_BITS-1:0] last_word,
  output logic [ERR_W-1:0]    parity_errs,
  output logic [ERR_W-1:0]    stop_errs,
  output logic [ERR_W-1:0]    frame_errs
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      word_count  <= '0;
      checksum    <= '0;
      last_word   <= '0;
      parity_errs <= '0;
      stop_errs   <= '0;
      frame_errs  <= '0;
    end else begin
      if (evt.word_done) begin
        word_count <= word_count + 1'b1;
        checksum   <= checksum + {{(32-MAX_BITS){1'b0}}, evt.word};
        last_word  <= evt.word;
        if (evt.par_err)  parity_errs <= parity_errs + 1'b1;
        if (evt.stop_err) stop_errs   <= stop_errs + 1'b1;
      end
      if (evt.frame_err) frame_errs <= frame_errs + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_stats.sv
module uart_rx_stats
  import uart_rx_stats_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int CNT_W       = 32,
  parameter int ERR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_RTS     = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic                stat_clear,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  input  logic                rxd,
  output logic                rts_n,
  output logic [CNT_W-1:0]    word_count,
  output logic [31:0]         checksum,
  output logic [MAX_BITS-1:0] last_word,
  output logic [ERR_W-1:0]    parity_errs,
  output logic [ERR_W-1:0]    stop_errs,
  output logic [ERR_W-1:0]    frame_errs
);
  logic      rx_s;
  rx_event_t evt;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
  );

  uart_rx_frame #(.DIV_W(DIV_W)) i_frame (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
    .rx_s(rx_s), .evt(evt)
  );

  uart_rx_tally #(.CNT_W(CNT_W), .ERR_W(ERR_W)) i_tally (
    .clk(clk), .rst(rst), .clear(stat_clear), .evt(evt),
    .word_count(word_count), .checksum(checksum), .last_word(last_word),
    .parity_errs(parity_errs), .stop_errs(stop_errs), .frame_errs(frame_errs)
  );

  generate
    if (HAS_RTS) begin : g_rts
      always_ff @(posedge clk) begin
        if (rst) rts_n <= 1'b1;
        else     rts_n <= ~run_en;
      end
    end else begin : g_no_rts
      assign rts_n = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/uart_rx_stats_chk.sv
module uart_rx_stats_chk #(
  parameter int CNT_W   = 32,
  parameter int ERR_W   = 16,
  parameter bit HAS_RTS = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             stat_clear,
  input logic             rts_n,
  input logic [CNT_W-1:0] word_count,
  input logic [31:0]      checksum,
  input logic [ERR_W-1:0] frame_errs
);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    stat_clear |=> (word_count == '0 && checksum == '0 && frame_errs == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_clear) && !$stable(word_count)) |-> (word_count == $past(word_count) + 1'b1));

  assert_sum_follows_count_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_clear) && $stable(word_count)) |-> $stable(checksum));

  assert_frame_err_no_word_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_clear) && !$stable(frame_errs)) |-> $stable(word_count));

  generate
    if (HAS_RTS) begin : g_rts_chk
      assert_rts_on_R9: assert property (@(posedge clk) disable iff (rst)
        run_en |=> !rts_n);
      assert_rts_off_R9: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> rts_n);
    end
  endgenerate
endmodule

bind uart_rx_stats uart_rx_stats_chk #(
  .CNT_W(CNT_W), .ERR_W(ERR_W), .HAS_RTS(HAS_RTS)
) i_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .stat_clear(stat_clear),
  .rts_n(rts_n), .word_count(word_count), .checksum(checksum),
  .frame_errs(frame_errs)
);

// File: tb/test_uart_rx_stats.sv
module test_uart_rx_stats;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        stat_clear = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [1:0]  cfg_len = 2'd1;
  logic [1:0]  cfg_par = 2'd0;
  logic        cfg_two_stop = 1'b0;
  logic        rxd = 1'b1;
  logic        rts_n;
  logic [31:0] word_count;
  logic [31:0] checksum;
  logic [8:0]  last_word;
  logic [15:0] parity_errs, stop_errs, frame_errs;

  int n_tests = 0;
  int n_fail = 0;
  int e_cnt = 0, e_par = 0, e_stop = 0, e_frm = 0;
  logic [31:0] e_sum = 0;
  logic [8:0]  e_last = 0;

  always #5 clk = ~clk;

  uart_rx_stats i_uart_rx_stats (
    .clk(clk), .rst(rst), .run_en(run_en), .stat_clear(stat_clear),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .rxd(rxd), .rts_n(rts_n),
    .word_count(word_count), .checksum(checksum), .last_word(last_word),
    .parity_errs(parity_errs), .stop_errs(stop_errs), .frame_errs(frame_errs)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " count"}, word_count, e_cnt);
    check({req, " sum"}, checksum, e_sum);
    check({req, " last"}, 32'(last_word), 32'(e_last));
    check({req, " par"}, 32'(parity_errs), e_par);
    check({req, " stop"}, 32'(stop_errs), e_stop);
    check({req, " frame"}, 32'(frame_errs), e_frm);
  endtask

  task automatic send_bit(logic b);
    rxd = b;
    repeat (DIV) @(negedge clk);
  endtask

  // pm: 0 none, 1 odd, 2 even; counted: frame is expected to be received
  task automatic send_frame(logic [8:0] w, int nb, int pm, bit two,
                            bit bad_par, bit bad_s1, bit bad_s2, bit counted);
    logic p;
    logic [8:0] m;
    p = 1'b0;
    m = w & 9'((1 << nb) - 1);
    cfg_len = 2'(nb - 7);
    cfg_par = 2'(pm);
    cfg_two_stop = two;
    @(negedge clk);
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      send_bit(m[i]);
      p = p ^ m[i];
    end
    if (pm != 0) send_bit(((pm == 1) ? ~p : p) ^ bad_par);
    send_bit(~bad_s1);
    if (two) send_bit(~bad_s2);
    rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    if (counted) begin
      e_cnt++;
      e_sum = e_sum + 32'(m);
      e_last = m;
      if (pm != 0 && bad_par) e_par++;
      if (bad_s1 || (two && bad_s2)) e_stop++;
    end
  endtask

  task automatic t_reset;
    check("R1 rts_n", 32'(rts_n), 1);
    check_all("R1");
  endtask

  task automatic t_len;
    send_frame(9'h0A5, 8, 0, 0, 0, 0, 0, 1);
    check_all("R2 8-bit");
    send_frame(9'h03C, 8, 0, 0, 0, 0, 0, 1);
    check_all("R5 second word");
    send_frame(9'h055, 7, 0, 0, 0, 0, 0, 1);
    check_all("R2 7-bit");
    send_frame(9'h1A7, 9, 0, 0, 0, 0, 0, 1);
    check_all("R2 9-bit");
  endtask

  task automatic t_parity;
    send_frame(9'h013, 8, 1, 0, 0, 0, 0, 1);
    check_all("R3 odd good");
    send_frame(9'h013, 8, 1, 0, 1, 0, 0, 1);
    check_all("R3 odd bad");
    send_frame(9'h06E, 7, 2, 0, 0, 0, 0, 1);
    check_all("R3 even good");
    send_frame(9'h1F0, 9, 2, 0, 1, 0, 0, 1);
    check_all("R3 even bad");
  endtask

  task automatic t_stop;
    send_frame(9'h0C3, 8, 0, 0, 0, 1, 0, 1);
    check_all("R4 one stop low");
    send_frame(9'h081, 8, 0, 1, 0, 0, 0, 1);
    check_all("R4 two stop good");
    send_frame(9'h07E, 8, 0, 1, 0, 0, 1, 1);
    check_all("R4 second stop low");
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    e_frm++;
    check_all("R6 glitch");
  endtask

  task automatic t_runstop;
    run_en = 1'b0;
    @(negedge clk);
    check("R9 rts off", 32'(rts_n), 1);
    send_frame(9'h0FF, 8, 0, 0, 0, 0, 0, 0);
    check_all("R7 disabled");
    run_en = 1'b1;
    @(negedge clk);
    check("R9 rts on", 32'(rts_n), 0);
    send_frame(9'h042, 8, 0, 0, 0, 0, 0, 1);
    check_all("R7 restart");
  endtask

  task automatic t_clear;
    stat_clear = 1'b1;
    @(negedge clk);
    stat_clear = 1'b0;
    e_cnt = 0; e_sum = 0; e_last = 0; e_par = 0; e_stop = 0; e_frm = 0;
    check_all("R8 clear");
    send_frame(9'h011, 8, 0, 0, 0, 0, 0, 1);
    check_all("R8 after clear");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_en = 1'b1;
    @(negedge clk);
    check("R9 rts low", 32'(rts_n), 0);
    t_len();
    t_parity();
    t_stop();
    t_glitch();
    t_runstop();
    t_clear();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule